// File: doc/BRIEF.md
# Floating-Point Compare Flag Unit

This block compares two IEEE-754 binary floating-point values and returns a four-bit condition code that shows whether the first operand is equal to, less than or greater than the second, or whether the pair is unordered. A mode input chooses between 32-bit and 64-bit operands. A 64-bit operand arrives as a low and a high 32-bit word. In single-precision mode only the low words are used.

Two further controls change how the compare works. The compare-with-zero mode ignores the second operand and compares the first operand against positive zero. When the flush enable is high, a subnormal operand is replaced by a zero of the same sign before the compare.

The caller presents the operands and pulses `start` for one cycle. On the next clock edge the unit registers the flags and raises `valid_o` for one cycle. The flags then hold their value until the next `start`.

Top module: `fp_compare_flags`

## Requirements
- R1: When the operands compare equal, `flags_o` is 4'b0110. The flag bit order is {N,Z,C,V}, with N at bit 3 and V at bit 0.
- R2: When the first operand is less than the second, `flags_o` is 4'b1000.
- R3: When the first operand is greater than the second, `flags_o` is 4'b0010.
- R4: When either operand is a NaN, `flags_o` is 4'b0011. A NaN is an operand whose exponent field is all ones and whose mantissa is nonzero. An infinity (exponent all ones, mantissa zero) is an ordered value that is larger than every finite value.
- R5: Positive zero and negative zero compare equal.
- R6: Ordered values compare by sign and magnitude. When the signs differ, the negative operand is the smaller one. When both operands are negative, the larger magnitude is the smaller value.
- R7: With `dbl_mode`=1, each operand is a 64-bit value: the low word gives bits 31:0 and the high word gives bits 63:32. With `dbl_mode`=0, only the low words are used and the high words have no effect.
- R8: With `cmp_zero`=1, `b_lo` and `b_hi` have no effect and the first operand is compared against +0.
- R9: With `ftz_en`=1, a subnormal operand (exponent field zero, mantissa nonzero) is treated as a zero of its own sign. With `ftz_en`=0, a subnormal operand is compared by its actual value.
- R10: `flags_o` takes its new value on the clock edge that samples `start`=1, and `valid_o` is high for exactly that one following cycle. While `start` is low, `flags_o` keeps its value and input changes do not affect it.
- R11: A synchronous reset (`rst`=1) sets `flags_o` to 0 and `valid_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to compare the presented operands |
| dbl_mode | input | 1 | 1 selects 64-bit operands, 0 selects 32-bit operands |
| cmp_zero | input | 1 | 1 compares the first operand against +0 |
| ftz_en | input | 1 | 1 treats subnormal operands as signed zero |
| a_lo | input | 32 | First operand, bits 31:0 |
| a_hi | input | 32 | First operand, bits 63:32 (64-bit mode only) |
| b_lo | input | 32 | Second operand, bits 31:0 |
| b_hi | input | 32 | Second operand, bits 63:32 (64-bit mode only) |
| flags_o | output | 4 | Registered result {N,Z,C,V} |
| valid_o | output | 1 | One-cycle strobe that marks a new result |

## Verification
On every cycle, the assertions check the handshake timing and the hold behaviour of R10, the clearing done by reset, and that every result is one of the four legal codes. They also check a few self-evident outcomes taken directly from the inputs: identical 32-bit non-NaN operands give the equal code, a 32-bit NaN first operand gives the unordered code, and a signed zero compared against zero gives the equal code.

Only the bench scenarios can show the ordering itself. This covers sign and magnitude order for negatives, infinities, the word order of 64-bit operands, the flushing of subnormals with the enable on and off, and the fact that unused words and the second operand in zero mode have no effect.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

    localparam int WORD_W   = 32;
    localparam int SP_EXP_W = 8;
    localparam int SP_MAN_W = 23;
    localparam int DP_EXP_W = 11;
    localparam int DP_MAN_W = 52;
    localparam int SP_W     = 1 + SP_EXP_W + SP_MAN_W;
    localparam int DP_W     = 1 + DP_EXP_W + DP_MAN_W;
    localparam int MAG_W    = DP_W - 1;
    localparam int FLAG_W   = 4;

    typedef enum logic [1:0] {
        RES_EQ = 2'd0,
        RES_LT = 2'd1,
        RES_GT = 2'd2,
        RES_UN = 2'd3
    } cmp_res_e;

    // Unpacked operand as seen by the ordering logic.
    typedef struct packed {
        logic             sign;
        logic             nan;
        logic             zero;
        logic [MAG_W-1:0] mag;
    } opnd_t;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    localparam opnd_t POS_ZERO = '{sign: 1'b0, nan: 1'b0, zero: 1'b1, mag: '0};

    function automatic flags_t res_to_flags(cmp_res_e r);
        flags_t f;
        unique case (r)
            RES_EQ:  f = '{n: 1'b0, z: 1'b1, c: 1'b1, v: 1'b0};
            RES_LT:  f = '{n: 1'b1, z: 1'b0, c: 1'b0, v: 1'b0};
            RES_GT:  f = '{n: 1'b0, z: 1'b0, c: 1'b1, v: 1'b0};
            default: f = '{n: 1'b0, z: 1'b0, c: 1'b1, v: 1'b1};
        endcase
        return f;
    endfunction

endpackage

// File: rtl/fpc_unpack.sv
module fpc_unpack #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int W    = 1 + EXP_W + MAN_W
) (
    input  logic            [W-1:0] raw_i,
    input  logic                    ftz_i,
    output fpc_pkg::opnd_t          op_o
);
    import fpc_pkg::*;

    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;
    logic             exp_zero;
    logic             exp_ones;
    logic             man_nz;
    logic             flush;

    always_comb begin
        exp_f    = raw_i[W-2:MAN_W];
        man_f    = raw_i[MAN_W-1:0];
        exp_zero = (exp_f == '0);
        exp_ones = &exp_f;
        man_nz   = |man_f;
        flush    = ftz_i && exp_zero && man_nz;

        op_o.sign = raw_i[W-1];
        op_o.nan  = exp_ones && man_nz;
        op_o.zero = (exp_zero && !man_nz) || flush;
        op_o.mag  = flush ? '0 : MAG_W'(raw_i[W-2:0]);
    end

endmodule

// File: rtl/fpc_order.sv
module fpc_order (
    input  fpc_pkg::opnd_t   a_i,
    input  fpc_pkg::opnd_t   b_i,
    output fpc_pkg::cmp_res_e res_o
);
    import fpc_pkg::*;

    logic mag_eq;
    logic mag_gt;

    always_comb begin
        mag_eq = (a_i.mag == b_i.mag);
        mag_gt = (a_i.mag > b_i.mag);
        if (a_i.nan || b_i.nan) begin
            res_o = RES_UN;
        end else if (a_i.zero && b_i.zero) begin
            res_o = RES_EQ;
        end else if (a_i.sign != b_i.sign) begin
            res_o = a_i.sign ? RES_LT : RES_GT;
        end else if (mag_eq) begin
            res_o = RES_EQ;
        end else begin
            res_o = (mag_gt ^ a_i.sign) ? RES_GT : RES_LT;
        end
    end

endmodule

// File: rtl/fp_compare_flags.sv
module fp_compare_flags #(
    parameter int WORD_W = fpc_pkg::WORD_W,
    localparam int FLAG_W = fpc_pkg::FLAG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              dbl_mode,
    input  logic              cmp_zero,
    input  logic              ftz_en,
    input  logic [WORD_W-1:0] a_lo,
    input  logic [WORD_W-1:0] a_hi,
    input  logic [WORD_W-1:0] b_lo,
    input  logic [WORD_W-1:0] b_hi,
    output logic [FLAG_W-1:0] flags_o,
    output logic              valid_o
);
    import fpc_pkg::*;

    localparam int N_OPND = 2;

    logic [2*WORD_W-1:0] raw [N_OPND];
    opnd_t               sp_op [N_OPND];
    opnd_t               dp_op [N_OPND];
    opnd_t               sel_a;
    opnd_t               sel_b;
    cmp_res_e            res;
    flags_t              flags_q;
    logic                valid_q;

    assign raw[0] = {a_hi, a_lo};
    assign raw[1] = {b_hi, b_lo};

    for (genvar gi = 0; gi < N_OPND; gi++) begin : g_opnd
        fpc_unpack #(.EXP_W(SP_EXP_W), .MAN_W(SP_MAN_W)) u_sp (
            .raw_i (raw[gi][SP_W-1:0]),
            .ftz_i (ftz_en),
            .op_o  (sp_op[gi])
        );
        fpc_unpack #(.EXP_W(DP_EXP_W), .MAN_W(DP_MAN_W)) u_dp (
            .raw_i (raw[gi][DP_W-1:0]),
            .ftz_i (ftz_en),
            .op_o  (dp_op[gi])
        );
    end

    always_comb begin
        sel_a = dbl_mode ? dp_op[0] : sp_op[0];
        if (cmp_zero) begin
            sel_b = POS_ZERO;
        end else begin
            sel_b = dbl_mode ? dp_op[1] : sp_op[1];
        end
    end

    fpc_order u_order (
        .a_i   (sel_a),
        .b_i   (sel_b),
        .res_o (res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= start;
            if (start) begin
                flags_q <= res_to_flags(res);
            end
        end
    end

    assign flags_o = flags_q;
    assign valid_o = valid_q;

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (flags_o == '0 && !valid_o));

    // R10
    valid_after_start_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> valid_o);

    // R10
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> !valid_o);

    // R10
    flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(flags_o));

    // R1
    legal_code_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (flags_o == 4'b0110 || flags_o == 4'b1000 ||
                     flags_o == 4'b0010 || flags_o == 4'b0011));

    // R1
    same_bits_equal_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !dbl_mode && !cmp_zero && a_lo == b_lo &&
         a_lo[30:23] != 8'hFF) |=> flags_o == 4'b0110);

    // R4
    nan_unordered_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !dbl_mode && !cmp_zero && a_lo[30:23] == 8'hFF &&
         a_lo[22:0] != '0) |=> flags_o == 4'b0011);

    // R8
    zero_vs_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !dbl_mode && cmp_zero && a_lo[30:0] == '0)
        |=> flags_o == 4'b0110);

endmodule

// File: tb/sim_fp_compare_flags.sv
module sim_fp_compare_flags;

    localparam logic [3:0] F_EQ = 4'b0110;
    localparam logic [3:0] F_LT = 4'b1000;
    localparam logic [3:0] F_GT = 4'b0010;
    localparam logic [3:0] F_UN = 4'b0011;

    localparam logic [31:0] S_ONE  = 32'h3F80_0000;
    localparam logic [31:0] S_TWO  = 32'h4000_0000;
    localparam logic [31:0] S_MONE = 32'hBF80_0000;
    localparam logic [31:0] S_MTWO = 32'hC000_0000;
    localparam logic [31:0] S_PZ   = 32'h0000_0000;
    localparam logic [31:0] S_NZ   = 32'h8000_0000;
    localparam logic [31:0] S_NAN  = 32'h7FC0_0000;
    localparam logic [31:0] S_INF  = 32'h7F80_0000;
    localparam logic [31:0] S_DEN  = 32'h0000_0001;
    localparam logic [31:0] S_NDEN = 32'h8000_0001;

    localparam logic [63:0] D_ONE  = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] D_TWO  = 64'h4000_0000_0000_0000;
    localparam logic [63:0] D_MONE = 64'hBFF0_0000_0000_0000;
    localparam logic [63:0] D_NAN  = 64'h7FF8_0000_0000_0000;
    localparam logic [63:0] D_DEN  = 64'h0000_0000_0000_0001;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        dbl_mode = 1'b0;
    logic        cmp_zero = 1'b0;
    logic        ftz_en = 1'b0;
    logic [31:0] a_lo = '0;
    logic [31:0] a_hi = '0;
    logic [31:0] b_lo = '0;
    logic [31:0] b_hi = '0;
    logic [3:0]  flags_o;
    logic        valid_o;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    fp_compare_flags u0 (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .dbl_mode (dbl_mode),
        .cmp_zero (cmp_zero),
        .ftz_en   (ftz_en),
        .a_lo     (a_lo),
        .a_hi     (a_hi),
        .b_lo     (b_lo),
        .b_hi     (b_hi),
        .flags_o  (flags_o),
        .valid_o  (valid_o)
    );

    task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Issue one compare, then check the result and the one-cycle strobe.
    task automatic do_cmp(input string tag, input logic dbl, input logic cz,
                          input logic ftz, input logic [63:0] a,
                          input logic [63:0] b, input logic [3:0] exp);
        @(negedge clk);
        dbl_mode = dbl; cmp_zero = cz; ftz_en = ftz;
        a_lo = a[31:0]; a_hi = a[63:32];
        b_lo = b[31:0]; b_hi = b[63:32];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(tag, {valid_o, flags_o}, {1'b1, exp});
        @(negedge clk);
        check({tag, " R10 strobe ends"}, {valid_o, flags_o}, {1'b0, exp});
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R11 reset state", {valid_o, flags_o}, 5'b0);
    endtask

    task automatic t_single_basic;
        do_cmp("R1 1.0==1.0", 0, 0, 0, {32'h0, S_ONE}, {32'h0, S_ONE}, F_EQ);
        do_cmp("R2 1.0<2.0", 0, 0, 0, {32'h0, S_ONE}, {32'h0, S_TWO}, F_LT);
        do_cmp("R3 2.0>1.0", 0, 0, 0, {32'h0, S_TWO}, {32'h0, S_ONE}, F_GT);
        do_cmp("R3 inf>2.0", 0, 0, 0, {32'h0, S_INF}, {32'h0, S_TWO}, F_GT);
        do_cmp("R4 nan a", 0, 0, 0, {32'h0, S_NAN}, {32'h0, S_ONE}, F_UN);
        do_cmp("R4 nan b", 0, 0, 0, {32'h0, S_ONE}, {32'h0, S_NAN}, F_UN);
        do_cmp("R4 inf==inf", 0, 0, 0, {32'h0, S_INF}, {32'h0, S_INF}, F_EQ);
    endtask

    task automatic t_signs;
        do_cmp("R5 +0==-0", 0, 0, 0, {32'h0, S_PZ}, {32'h0, S_NZ}, F_EQ);
        do_cmp("R6 -1<1", 0, 0, 0, {32'h0, S_MONE}, {32'h0, S_ONE}, F_LT);
        do_cmp("R6 -2<-1", 0, 0, 0, {32'h0, S_MTWO}, {32'h0, S_MONE}, F_LT);
        do_cmp("R6 -1>-2", 0, 0, 0, {32'h0, S_MONE}, {32'h0, S_MTWO}, F_GT);
        do_cmp("R6 -0<1", 0, 0, 0, {32'h0, S_NZ}, {32'h0, S_ONE}, F_LT);
    endtask

    task automatic t_double;
        do_cmp("R7 hi words ignored in single", 0, 0, 0,
               {32'hDEAD_BEEF, S_ONE}, {32'h1234_5678, S_ONE}, F_EQ);
        do_cmp("R7 dp 2.0>1.0", 1, 0, 0, D_TWO, D_ONE, F_GT);
        do_cmp("R7 dp -1<1", 1, 0, 0, D_MONE, D_ONE, F_LT);
        do_cmp("R7 dp word order", 1, 0, 0, D_DEN, 64'h0000_0001_0000_0000, F_LT);
        do_cmp("R7 dp nan", 1, 0, 0, D_ONE, D_NAN, F_UN);
        do_cmp("R7 dp equal", 1, 0, 0, D_TWO, D_TWO, F_EQ);
    endtask

    task automatic t_zero_mode;
        do_cmp("R8 -1 vs zero", 0, 1, 0, {32'h0, S_MONE}, {32'h0, S_MONE}, F_LT);
        do_cmp("R8 1 vs zero", 0, 1, 0, {32'h0, S_ONE}, {32'h0, S_NAN}, F_GT);
        do_cmp("R8 nan vs zero", 0, 1, 0, {32'h0, S_NAN}, {32'h0, S_ONE}, F_UN);
        do_cmp("R8 dp -0 vs zero", 1, 1, 0, 64'h8000_0000_0000_0000, D_TWO, F_EQ);
    endtask

    task automatic t_flush;
        do_cmp("R9 ftz off denorm>0", 0, 0, 0, {32'h0, S_DEN}, {32'h0, S_PZ}, F_GT);
        do_cmp("R9 ftz on denorm==0", 0, 0, 1, {32'h0, S_DEN}, {32'h0, S_PZ}, F_EQ);
        do_cmp("R9 ftz on -den==+den", 0, 0, 1, {32'h0, S_NDEN}, {32'h0, S_DEN}, F_EQ);
        do_cmp("R9 ftz off -den<+den", 0, 0, 0, {32'h0, S_NDEN}, {32'h0, S_DEN}, F_LT);
        do_cmp("R9 ftz zero mode", 0, 1, 1, {32'h0, S_NDEN}, {32'h0, S_ONE}, F_EQ);
        do_cmp("R9 dp ftz on", 1, 0, 1, D_DEN, 64'h0, F_EQ);
        do_cmp("R9 dp ftz off", 1, 0, 0, D_DEN, 64'h0, F_GT);
    endtask

    task automatic t_hold;
        do_cmp("R10 setup", 0, 0, 0, {32'h0, S_ONE}, {32'h0, S_TWO}, F_LT);
        @(negedge clk);
        a_lo = S_NAN; b_lo = S_ONE; cmp_zero = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R10 hold without start", {valid_o, flags_o}, {1'b0, F_LT});
    endtask

    task automatic t_mid_reset;
        do_cmp("R11 setup", 0, 0, 0, {32'h0, S_TWO}, {32'h0, S_ONE}, F_GT);
        @(negedge clk);
        rst = 1'b1;
        start = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        start = 1'b0;
        check("R11 reset clears", {valid_o, flags_o}, 5'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_single_basic();
        t_signs();
        t_double();
        t_zero_mode();
        t_flush();
        t_hold();
        t_mid_reset();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule